// File: doc/BRIEF.md
# Oversampling Serial Receiver with Per-Byte Error Status

This block receives asynchronous serial frames on one line. A baud-rate tick, pulsed once for each of `OVS` sub-intervals of a bit, drives it. The line first passes through a synchroniser. A start edge must hold low for half a bit before the block accepts it. Each later bit is decided by a three-sample majority vote around the bit centre. A frame carries eight data bits, LSB first. It may add a ninth data bit, which is the address marker, and an optional parity bit. One stop bit ends the frame.

Completed characters enter a two-entry holding buffer. Each entry keeps its own framing, parity and overrun status. If both entries are full, one further completed character may wait in the shift stage. A host reads the buffer through a single read port. The data and status on that port always describe the oldest unread character. A read strobe advances the buffer to the next character. In multi-processor mode, the block discards every frame whose ninth bit is 0.

Top module: `serial_rx_errbuf`

## Requirements
- R1: After reset, `rd_valid`, `rd_frame_err`, `rd_par_err` and `rd_overrun` are 0.
- R2: A low level on `rx_line` that lasts less than half a bit period (fewer than `OVS/2` ticks) does not start a frame, and no character is stored.
- R3: Each bit is decided by majority of samples `OVS/2-1`, `OVS/2` and `OVS/2+1` within the bit. A one-tick disturbance near the bit centre does not change the received value.
- R4: Data bits arrive LSB first. `rd_data[7:0]` holds the eight data bits. `rd_data[8]` holds the ninth bit when `cfg_ninth`=1 and is 0 otherwise.
- R5: Up to three characters may be received with no read: two in the buffer and one held in the shift stage. All three are read back in arrival order.
- R6: `rd_frame_err` is 1 for a character whose stop bit was decided as 0, and 0 when it was decided as 1.
- R7: When `cfg_par_en`=1, a parity bit follows the data bits. Its expected value makes the count of ones over the data bits and the parity bit even when `cfg_par_odd`=0, and odd when `cfg_par_odd`=1. `rd_par_err` is 1 only for a character received with parity enabled whose parity bit did not match.
- R8: An overrun occurs when a start bit is accepted while both buffer entries are full and a character waits in the shift stage. The waiting character is lost, and both buffered characters keep their data. `rd_overrun` is then 1 for the newer of the two buffered characters.
- R9: The status outputs belong to the character at the buffer head. They hold until a read (`rd_en`=1 with `rd_valid`=1) advances the head.
- R10: With `cfg_mpm`=1, a frame whose ninth bit is 0 is discarded, and one whose ninth bit is 1 is stored.
- R11: A read strobe while `rd_valid`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One pulse per oversampling interval (OVS per bit) |
| rx_line | input | 1 | Serial input, idle high |
| cfg_ninth | input | 1 | Frames carry a ninth data bit |
| cfg_par_en | input | 1 | Frames carry a parity bit that is checked |
| cfg_par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| cfg_mpm | input | 1 | Keep only frames whose ninth bit is 1 |
| rd_en | input | 1 | Read strobe: pops the head character |
| rd_valid | output | 1 | The buffer holds at least one character |
| rd_data | output | 9 | Head character, with the ninth bit in [8] |
| rd_frame_err | output | 1 | Head character had a stop-bit error |
| rd_par_err | output | 1 | Head character had a parity mismatch |
| rd_overrun | output | 1 | A character was lost after the head character was stored |

## Verification
A wrong oversampling phase, or a wrong bit index, shows up at the read port one character later as shifted or bit-swapped data. A fault in the per-entry status, or in the buffer's shift on a read, only appears once the host reaches the affected character. A lost or duplicated character at overrun is therefore seen only after two or three reads. The bench reads every stored character back, checks the data and all three flags each time, and then checks that `rd_valid` drops at the expected point.

// File: rtl/serial_rx_pkg.sv
// Shared types for the serial receiver: word widths and the buffer entry
// carrying a received character together with its status bits.
package serial_rx_pkg;
    localparam int RX_DATA_W = 8;
    localparam int RX_WORD_W = RX_DATA_W + 1;

    typedef struct packed {
        logic [RX_WORD_W-1:0] data;
        logic                 fe;
        logic                 pe;
        logic                 dor;
    } rx_entry_t;
endpackage

// File: rtl/serial_rx_sync.sv
// Line synchroniser: brings the asynchronous serial input into the clock
// domain through STAGES flops. Assumes an idle-high line, so it resets to 1.
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            // single flop capture
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= din;
            end
        end else begin : g_chain
            // multi-flop shift chain
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/serial_rx_deframer.sv
// Frame decoder: it qualifies the start edge over half a bit, votes each bit
// from three samples around the centre, and assembles data, parity and stop.
// It pulses start_det when a start bit is accepted and frame_done with the
// finished entry. Assumes a synchronised input and OVS >= 8.
module serial_rx_deframer
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx_s,
    input  logic      cfg_ninth,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    output logic      start_det,
    output logic      frame_done,
    output rx_entry_t frame_ent
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(RX_WORD_W);
    localparam logic [CW-1:0] C_ACC  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] C_MID  = CW'(OVS/2);
    localparam logic [CW-1:0] C_VOTE = CW'(OVS/2 + 1);
    localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);
    localparam logic [IW-1:0] I_LAST8 = IW'(RX_DATA_W - 1);
    localparam logic [IW-1:0] I_LAST9 = IW'(RX_DATA_W);

    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

    st_t                  st;
    logic [CW-1:0]        cnt;
    logic [IW-1:0]        bit_idx;
    logic                 v_a, v_b;
    logic [RX_WORD_W-1:0] shreg;
    logic                 l_ninth, l_pen, l_podd;
    logic                 par_acc, par_bad;
    logic                 vote;
    logic [IW-1:0]        last_idx;

    assign vote     = (v_a & v_b) | (v_a & rx_s) | (v_b & rx_s);
    assign last_idx = l_ninth ? I_LAST9 : I_LAST8;

    // Frame state machine, sample counter and bit assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            v_a        <= 1'b1;
            v_b        <= 1'b1;
            shreg      <= '0;
            l_ninth    <= 1'b0;
            l_pen      <= 1'b0;
            l_podd     <= 1'b0;
            par_acc    <= 1'b0;
            par_bad    <= 1'b0;
            start_det  <= 1'b0;
            frame_done <= 1'b0;
            frame_ent  <= '0;
        end else begin
            start_det  <= 1'b0;
            frame_done <= 1'b0;
            if (tick) begin
                cnt <= (cnt == C_LAST) ? '0 : cnt + 1'b1;
                if (cnt == C_ACC) v_a <= rx_s;
                if (cnt == C_MID) v_b <= rx_s;
                case (st)
                    S_IDLE: begin
                        // the first low sample counts as sample 0
                        cnt <= rx_s ? '0 : CW'(1);
                        if (!rx_s) st <= S_START;
                    end
                    S_START: begin
                        if (rx_s && cnt <= C_ACC) begin
                            st <= S_IDLE;
                            cnt <= '0;
                        end else begin
                            if (cnt == C_ACC) begin
                                start_det <= 1'b1;
                                l_ninth   <= cfg_ninth;
                                l_pen     <= cfg_par_en;
                                l_podd    <= cfg_par_odd;
                            end
                            if (cnt == C_LAST) begin
                                st      <= S_DATA;
                                bit_idx <= '0;
                                shreg   <= '0;
                                par_acc <= 1'b0;
                                par_bad <= 1'b0;
                            end
                        end
                    end
                    S_DATA: begin
                        if (cnt == C_VOTE) begin
                            shreg[bit_idx] <= vote;
                            par_acc        <= par_acc ^ vote;
                            if (bit_idx == last_idx) st <= l_pen ? S_PAR : S_STOP;
                            else                     bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (cnt == C_VOTE) begin
                            par_bad <= (vote ^ par_acc) != l_podd;
                            st      <= S_STOP;
                        end
                    end
                    S_STOP: begin
                        if (cnt == C_VOTE) begin
                            frame_done     <= 1'b1;
                            frame_ent.data <= shreg;
                            frame_ent.fe   <= ~vote;
                            frame_ent.pe   <= l_pen & par_bad;
                            frame_ent.dor  <= 1'b0;
                            st             <= S_IDLE;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // R2: a start is accepted only on a line seen low at the acceptance sample
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |-> !$past(rx_s));

    // R4: a frame cannot finish in the same cycle a new start is accepted
    p_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !start_det);
endmodule

// File: rtl/serial_rx_holdbuf.sv
// Two-entry receive buffer with one extra waiting slot in the shift stage.
// It pops on a read, moves the waiting character in when room appears, and
// applies the overrun rule on a start bit. Assumes push and start_det never
// coincide; both come from one frame decoder.
module serial_rx_holdbuf
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  rx_entry_t  push_ent,
    input  logic       start_det,
    input  logic       pop_req,
    output rx_entry_t  head,
    output logic [1:0] level
);
    rx_entry_t q0, q1, wt;
    logic      wait_v;
    logic      pop;

    assign pop  = pop_req && (level != 2'd0);
    assign head = q0;

    // Buffer fill, pop, waiting-slot transfer and overrun handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0     <= '0;
            q1     <= '0;
            wt     <= '0;
            wait_v <= 1'b0;
            level  <= 2'd0;
        end else if (pop) begin
            q0 <= q1;
            if (wait_v) begin
                q1     <= wt;
                wait_v <= 1'b0;
            end else if (push) begin
                if (level == 2'd2) q1 <= push_ent;
                else               q0 <= push_ent;
            end else begin
                level <= level - 2'd1;
            end
        end else begin
            if (push) begin
                case (level)
                    2'd0: begin q0 <= push_ent; level <= 2'd1; end
                    2'd1: begin q1 <= push_ent; level <= 2'd2; end
                    default: begin wt <= push_ent; wait_v <= 1'b1; end
                endcase
            end
            if (start_det && wait_v) begin
                wait_v <= 1'b0;
                q1.dor <= 1'b1;
            end
        end
    end

    // R5: a waiting character exists only behind a full buffer
    p_wait_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wait_v |-> level == 2'd2);

    // R5: a new character never arrives while one is still waiting
    p_push_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !wait_v);

    // R8: an overrun keeps the head intact and the buffer full
    p_overrun_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && wait_v && !pop_req) |=> ($stable(q0.data) && level == 2'd2 && !wait_v));

    // R11: a read of an empty buffer leaves it empty
    p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && level == 2'd0 && !push) |=> level == 2'd0);
endmodule

// File: rtl/serial_rx_errbuf.sv
// Top of the serial receiver: synchroniser, frame decoder, address filter
// and two-entry buffer. The read port shows the head character and its own
// status bits, forced to 0 while the buffer is empty. Assumes baud_tick
// pulses OVS times per bit.
module serial_rx_errbuf
    import serial_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 rx_line,
    input  logic                 cfg_ninth,
    input  logic                 cfg_par_en,
    input  logic                 cfg_par_odd,
    input  logic                 cfg_mpm,
    input  logic                 rd_en,
    output logic                 rd_valid,
    output logic [RX_WORD_W-1:0] rd_data,
    output logic                 rd_frame_err,
    output logic                 rd_par_err,
    output logic                 rd_overrun
);
    logic       rx_s;
    logic       start_det, frame_done, push;
    rx_entry_t  frame_ent, head;
    logic [1:0] level;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
    );

    serial_rx_deframer #(.OVS(OVS)) u_deframer (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx_s(rx_s),
        .cfg_ninth(cfg_ninth), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .start_det(start_det), .frame_done(frame_done), .frame_ent(frame_ent)
    );

    // address filter: in multi-processor mode only address frames pass
    assign push = frame_done && !(cfg_mpm && !frame_ent.data[RX_WORD_W-1]);

    serial_rx_holdbuf u_buf (
        .clk(clk), .rst_n(rst_n), .push(push), .push_ent(frame_ent),
        .start_det(start_det), .pop_req(rd_en), .head(head), .level(level)
    );

    assign rd_valid     = (level != 2'd0);
    assign rd_data      = rd_valid ? head.data : '0;
    assign rd_frame_err = rd_valid & head.fe;
    assign rd_par_err   = rd_valid & head.pe;
    assign rd_overrun   = rd_valid & head.dor;

    // R10: a discarded non-address frame leaves the buffer fill unchanged
    p_drop_nonaddr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && cfg_mpm && !frame_ent.data[RX_WORD_W-1] && !rd_en) |=> $stable(level));

    // R9: with no read, a stored head keeps its status bits
    p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en) |=> ($stable(rd_frame_err) && $stable(rd_par_err) && $stable(rd_data)));
endmodule

// File: tb/serial_rx_errbuf_tb.sv
module serial_rx_errbuf_tb;
    localparam int BIT_CLK = 64;   // 16 ticks x 4 clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic rx_line = 1'b1;
    logic cfg_ninth = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_mpm = 1'b0;
    logic rd_en = 1'b0;
    logic rd_valid, rd_frame_err, rd_par_err, rd_overrun;
    logic [8:0] rd_data;
    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] tdiv = 2'd0;

    serial_rx_errbuf u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
        .cfg_ninth(cfg_ninth), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_mpm(cfg_mpm), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_frame_err(rd_frame_err), .rd_par_err(rd_par_err), .rd_overrun(rd_overrun)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tdiv      <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd3);
    end

    function automatic logic [8:0] exp_word(input logic [8:0] d, input logic ninth);
        return ninth ? d : {1'b0, d[7:0]};
    endfunction

    function automatic logic par_bit(input logic [8:0] d, input logic ninth, input logic odd);
        return (^exp_word(d, ninth)) ^ odd;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send one frame; glitch_bit >= 0 flips one data bit for 4 clocks near its centre
    task automatic send(input logic [8:0] d, input logic flip_par, input logic stop_v,
                        input int glitch_bit);
        int nb;
        nb = cfg_ninth ? 9 : 8;
        rx_line = 1'b0;
        wait_clk(BIT_CLK);
        for (int i = 0; i < nb; i++) begin
            rx_line = d[i];
            if (glitch_bit == i) begin
                wait_clk(30);
                rx_line = ~d[i];
                wait_clk(4);
                rx_line = d[i];
                wait_clk(30);
            end else begin
                wait_clk(BIT_CLK);
            end
        end
        if (cfg_par_en) begin
            rx_line = par_bit(d, cfg_ninth, cfg_par_odd) ^ flip_par;
            wait_clk(BIT_CLK);
        end
        rx_line = stop_v;
        wait_clk(BIT_CLK);
        rx_line = 1'b1;
        wait_clk(32);
    endtask

    task automatic read_chk(input string req, input logic [8:0] d, input logic fe,
                            input logic pe, input logic dor);
        check({req, " valid"}, int'(rd_valid), 1);
        check({req, " data"}, int'(rd_data), int'(d));
        check({req, " fe"}, int'(rd_frame_err), int'(fe));
        check({req, " pe"}, int'(rd_par_err), int'(pe));
        check({req, " dor"}, int'(rd_overrun), int'(dor));
        rd_en = 1'b1;
        wait_clk(1);
        rd_en = 1'b0;
        wait_clk(1);
    endtask

    initial begin
        logic [8:0] d;
        logic fl, st;
        void'($urandom(32'd1234));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        check("R1 valid", int'(rd_valid), 0);
        check("R1 fe", int'(rd_frame_err), 0);
        check("R1 pe", int'(rd_par_err), 0);
        check("R1 dor", int'(rd_overrun), 0);

        // R4 plain 8-bit frame, LSB first
        send(9'h0A5, 1'b0, 1'b1, -1);
        read_chk("R4 8bit", 9'h0A5, 1'b0, 1'b0, 1'b0);
        check("R4 empty after read", int'(rd_valid), 0);

        // R2 short low pulse is rejected
        rx_line = 1'b0; wait_clk(20); rx_line = 1'b1; wait_clk(300);
        check("R2 glitch start", int'(rd_valid), 0);

        // R3 one-tick disturbance near a bit centre
        send(9'h03C, 1'b0, 1'b1, 2);
        read_chk("R3 vote", 9'h03C, 1'b0, 1'b0, 1'b0);
        send(9'h0C3, 1'b0, 1'b1, 6);
        read_chk("R3 vote b6", 9'h0C3, 1'b0, 1'b0, 1'b0);

        // R6 stop bit errors
        send(9'h055, 1'b0, 1'b0, -1);
        read_chk("R6 stop low", 9'h055, 1'b1, 1'b0, 1'b0);
        send(9'h056, 1'b0, 1'b1, -1);
        read_chk("R6 stop high", 9'h056, 1'b0, 1'b0, 1'b0);

        // R7 parity, even and odd
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send(9'h071, 1'b0, 1'b1, -1);
        read_chk("R7 even ok", 9'h071, 1'b0, 1'b0, 1'b0);
        send(9'h071, 1'b1, 1'b1, -1);
        read_chk("R7 even bad", 9'h071, 1'b0, 1'b1, 1'b0);
        cfg_par_odd = 1'b1;
        send(9'h0F0, 1'b0, 1'b1, -1);
        read_chk("R7 odd ok", 9'h0F0, 1'b0, 1'b0, 1'b0);
        send(9'h0F0, 1'b1, 1'b1, -1);
        read_chk("R7 odd bad", 9'h0F0, 1'b0, 1'b1, 1'b0);
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // R5/R9 three frames with no read, status per character
        send(9'h011, 1'b0, 1'b1, -1);
        send(9'h022, 1'b0, 1'b0, -1);
        send(9'h033, 1'b0, 1'b1, -1);
        wait_clk(50);
        check("R9 head hold fe", int'(rd_frame_err), 0);
        read_chk("R5 first", 9'h011, 1'b0, 1'b0, 1'b0);
        read_chk("R5 R9 second", 9'h022, 1'b1, 1'b0, 1'b0);
        read_chk("R5 third", 9'h033, 1'b0, 1'b0, 1'b0);
        check("R5 drained", int'(rd_valid), 0);

        // R8 overrun: fourth start while full and one waiting
        send(9'h0A1, 1'b0, 1'b1, -1);
        send(9'h0A2, 1'b0, 1'b1, -1);
        send(9'h0A3, 1'b0, 1'b1, -1);
        send(9'h0A4, 1'b0, 1'b1, -1);
        read_chk("R8 head kept", 9'h0A1, 1'b0, 1'b0, 1'b0);
        read_chk("R8 newer flagged", 9'h0A2, 1'b0, 1'b0, 1'b1);
        read_chk("R8 after loss", 9'h0A4, 1'b0, 1'b0, 1'b0);
        check("R8 lost char", int'(rd_valid), 0);

        // R10 multi-processor filter, R4 ninth bit position
        cfg_ninth = 1'b1; cfg_mpm = 1'b1;
        send(9'h05A, 1'b0, 1'b1, -1);
        check("R10 drop data frame", int'(rd_valid), 0);
        send(9'h15A, 1'b0, 1'b1, -1);
        read_chk("R10 R4 address kept", 9'h15A, 1'b0, 1'b0, 1'b0);
        cfg_mpm = 1'b0;
        send(9'h05A, 1'b0, 1'b1, -1);
        read_chk("R10 off keeps data", 9'h05A, 1'b0, 1'b0, 1'b0);
        cfg_ninth = 1'b0;

        // R11 read of empty buffer
        rd_en = 1'b1; wait_clk(3); rd_en = 1'b0; wait_clk(1);
        check("R11 empty read", int'(rd_valid), 0);
        send(9'h0E7, 1'b0, 1'b1, -1);
        read_chk("R11 next frame", 9'h0E7, 1'b0, 1'b0, 1'b0);
        check("R11 single entry", int'(rd_valid), 0);

        // random frames with random format, read back one by one
        for (int k = 0; k < 40; k++) begin
            d = 9'($urandom);
            cfg_ninth   = 1'($urandom);
            cfg_par_en  = 1'($urandom);
            cfg_par_odd = 1'($urandom);
            fl = cfg_par_en & 1'($urandom);
            st = ($urandom % 8) != 0;
            send(d, fl, st, -1);
            read_chk("R4 R6 R7 random", exp_word(d, cfg_ninth), ~st, fl, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule